// File: doc/BRIEF.md
# PLL Bring-Up and Shutdown Sequencer

This block is a hardware state machine that brings up and shuts down the reference PLL of a serial PHY. It works as a simple master on a register bus. An init request first reads the PLL status. If the PLL is already locked, the block only makes sure the PLL is out of idle. If it is not locked, the block looks up divider settings for the reference clock rate. It then writes five configuration fields, each by read-modify-write, writes the GO register, and polls for lock within a bounded time.

An exit request puts the PLL into idle. The block then waits for the oscillator and the regulator to both report power-down, and ends with a set-then-clear pulse on one bit of a separate reset register.

Each operation ends with a one-cycle `done` or a one-cycle `error`. `busy` is high while an operation is running.

Top module: `pllseq_ctrl`

## Requirements
- R1: The reference rate `ref_khz` (in kHz) selects the multiplier M from the table 12000→1000, 16800→714, 19200→625, 20000→600, 26000→461, 38400→312. Every entry also uses N=7, DCO select=4, SD=6 and fractional M=0.
- R2: Programming makes exactly six writes, in this order. Field writes are read-modify-write and keep every bit outside the field:
  - N into config1 (0x0C) bits 8:1
  - DCO select into config2 (0x10) bits 3:1
  - M into config1 bits 20:9
  - fractional M into config4 (0x20) bits 17:0
  - SD into config3 (0x14) bits 17:10
  - the value 1 into GO (0x08)
- R3: After GO, the block reads status (0x04) until bit 1 (lock) is set, then pulses `done`. If lock has not appeared within `CLK_HZ/1000*TIMEOUT_MS` cycles of polling, it pulses `error`.
- R4: When an init finds the PLL unlocked and `ref_khz` matches no table entry, the block pulses `error` and makes no bus write.
- R5: When an init finds status bit 1 already set, it does no programming. If config2 bit 0 (idle) is set, the block clears only that bit and then waits for lock as in R3. Otherwise it pulses `done` with no write.
- R6: An exit sets config2 bit 0 and keeps the other bits. It then polls status until bits 16 and 15 are both set. If they are not both set within the timeout, the block pulses `error` and makes no write to the reset register.
- R7: After power-down is seen, the block reads the reset register at `RST_ADDR` (default 0x040). It writes that value with bit 18 set, then writes it again with bit 18 clear, and then pulses `done`. The other bits of the register are left unchanged.
- R8: `bus_rd` and `bus_wr` are never high together. A pending request keeps its strobe, address and write data stable until `bus_ack`.
- R9: `init_req` and `exit_req` are ignored while `busy` is high. `done` and `error` last one cycle each and are never high together. Init takes priority when both requests arrive together.
- R10: After reset, `busy`, `done`, `error`, `bus_rd` and `bus_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Start a bring-up |
| exit_req | input | 1 | Start a shutdown |
| ref_khz | input | RATE_W | Reference clock rate in kHz |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Completes the pending transaction |
| done | output | 1 | One-cycle pulse: the operation succeeded |
| error | output | 1 | One-cycle pulse: the operation failed |
| busy | output | 1 | An operation is in progress |

## Verification
A wrong field index or merge mask shows up as soon as the next write completes. Either the written register value loses bits outside the field, or the order of write addresses differs from the fixed sequence. A wrong branch on the status read is caught within one bus transaction: writes appear where none should, or a reset-register write appears after a failed power-down. A miscounted timeout moves the `error` pulse outside a window of a few dozen cycles around the configured limit. A request leaking in while `busy` is high leaves a config2 idle bit or reset writes behind in the register model.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int DW   = 32;
    localparam int NFLD = 5;

    // register map (byte offsets)
    localparam logic [11:0] OFS_STAT = 12'h004;
    localparam logic [11:0] OFS_GO   = 12'h008;
    localparam logic [11:0] OFS_CFG1 = 12'h00C;
    localparam logic [11:0] OFS_CFG2 = 12'h010;
    localparam logic [11:0] OFS_CFG3 = 12'h014;
    localparam logic [11:0] OFS_CFG4 = 12'h020;

    localparam int LOCK_BIT  = 1;
    localparam int IDLE_BIT  = 0;
    localparam int OSC_PD_B  = 16;
    localparam int LDO_PD_B  = 15;
    localparam int RST_BIT   = 18;

    // per-rate multiplier table
    localparam int NRATES = 6;
    localparam logic [15:0] RATE_KHZ [NRATES] = '{16'd12000, 16'd16800, 16'd19200,
                                                  16'd20000, 16'd26000, 16'd38400};
    localparam logic [11:0] M_VAL    [NRATES] = '{12'd1000, 12'd714, 12'd625,
                                                  12'd600,  12'd461, 12'd312};
    localparam logic [DW-1:0] N_VAL   = 32'd7;
    localparam logic [DW-1:0] SEL_VAL = 32'd4;
    localparam logic [DW-1:0] SD_VAL  = 32'd6;
    localparam logic [DW-1:0] MF_VAL  = 32'd0;

    typedef enum logic [3:0] {
        S_WAIT, S_CHK, S_FRD, S_FWR, S_GO, S_PLOCK,
        S_WKRD, S_WKWR, S_SLRD, S_SLWR, S_PPD,
        S_RRD, S_RSET, S_RCLR
    } seq_state_e;

    // field programming order: N, DCO select, M, fractional M, SD
    function automatic logic [11:0] fld_addr(input logic [2:0] k);
        case (k)
            3'd0:    return OFS_CFG1;
            3'd1:    return OFS_CFG2;
            3'd2:    return OFS_CFG1;
            3'd3:    return OFS_CFG4;
            default: return OFS_CFG3;
        endcase
    endfunction

    function automatic int fld_lsb(input logic [2:0] k);
        case (k)
            3'd0:    return 1;
            3'd1:    return 1;
            3'd2:    return 9;
            3'd3:    return 0;
            default: return 10;
        endcase
    endfunction

    function automatic int fld_width(input logic [2:0] k);
        case (k)
            3'd0:    return 8;
            3'd1:    return 3;
            3'd2:    return 12;
            3'd3:    return 18;
            default: return 8;
        endcase
    endfunction

    function automatic logic [DW-1:0] fld_mask(input logic [2:0] k);
        return ((32'd1 << fld_width(k)) - 32'd1) << fld_lsb(k);
    endfunction

endpackage

// File: rtl/pllseq_divtab.sv
module pllseq_divtab
    import pllseq_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int M_W    = 12
) (
    input  logic [RATE_W-1:0] rate_khz,
    output logic              hit,
    output logic [M_W-1:0]    m_sel
);
    logic [NRATES-1:0] match;

    for (genvar g = 0; g < NRATES; g++) begin : g_cmp
        assign match[g] = (rate_khz == RATE_W'(RATE_KHZ[g]));
    end

    always_comb begin
        hit   = |match;
        m_sel = '0;
        for (int i = 0; i < NRATES; i++) begin
            if (match[i]) m_sel = M_W'(M_VAL[i]);
        end
    end
endmodule

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)          cnt_d = '0;
        else if (!expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the limit is only reached while a poll is running
    p_expire_in_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned TIMEOUT_MS = 100,
    parameter int          RATE_W     = 16,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] RST_ADDR   = 12'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              exit_req,
    input  logic [RATE_W-1:0] ref_khz,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              error,
    output logic              busy
);
    localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
    localparam int          M_W     = 12;

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        fld;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     hold;
        logic              done;
        logic              error;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              tab_hit;
    logic [M_W-1:0]    tab_m;
    logic              tmo;
    logic              polling;
    logic              want_rd, want_wr;
    logic [11:0]       want_addr;
    logic              ack_ev;
    logic [DW-1:0]     fval, fmask, fnew;

    pllseq_divtab #(.RATE_W(RATE_W), .M_W(M_W)) u_tab (
        .rate_khz (ref_khz),
        .hit      (tab_hit),
        .m_sel    (tab_m)
    );

    assign polling = (ctl_q.st == S_PLOCK) || (ctl_q.st == S_PPD);

    pllseq_timer #(.LIMIT(TMO_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (polling),
        .expired (tmo)
    );

    // which transaction each state needs
    always_comb begin
        want_rd   = 1'b0;
        want_wr   = 1'b0;
        want_addr = '0;
        case (ctl_q.st)
            S_CHK, S_PLOCK, S_PPD: begin want_rd = 1'b1; want_addr = OFS_STAT; end
            S_FRD:                 begin want_rd = 1'b1; want_addr = fld_addr(ctl_q.fld); end
            S_FWR:                 begin want_wr = 1'b1; want_addr = fld_addr(ctl_q.fld); end
            S_GO:                  begin want_wr = 1'b1; want_addr = OFS_GO; end
            S_WKRD, S_SLRD:        begin want_rd = 1'b1; want_addr = OFS_CFG2; end
            S_WKWR, S_SLWR:        begin want_wr = 1'b1; want_addr = OFS_CFG2; end
            S_RRD:                 begin want_rd = 1'b1; want_addr = RST_ADDR; end
            S_RSET, S_RCLR:        begin want_wr = 1'b1; want_addr = RST_ADDR; end
            default: ;
        endcase
    end

    // field merge for read-modify-write
    always_comb begin
        case (ctl_q.fld)
            3'd0:    fval = N_VAL;
            3'd1:    fval = SEL_VAL;
            3'd2:    fval = DW'(tab_m);
            3'd3:    fval = MF_VAL;
            default: fval = SD_VAL;
        endcase
        fmask = fld_mask(ctl_q.fld);
        fnew  = (bus_rdata & ~fmask) | ((fval << fld_lsb(ctl_q.fld)) & fmask);
    end

    assign ack_ev = (ctl_q.rd || ctl_q.wr) && bus_ack;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.error = 1'b0;

        if (!ctl_q.rd && !ctl_q.wr) begin
            ctl_d.rd   = want_rd;
            ctl_d.wr   = want_wr;
            ctl_d.addr = ADDR_W'(want_addr);
        end else if (ack_ev) begin
            ctl_d.rd = 1'b0;
            ctl_d.wr = 1'b0;
        end

        case (ctl_q.st)
            S_WAIT: begin
                if (init_req)      ctl_d.st = S_CHK;
                else if (exit_req) ctl_d.st = S_SLRD;
            end
            S_CHK: if (ack_ev) begin
                if (bus_rdata[LOCK_BIT]) ctl_d.st = S_WKRD;
                else if (!tab_hit) begin
                    ctl_d.st    = S_WAIT;
                    ctl_d.error = 1'b1;
                end else begin
                    ctl_d.fld = '0;
                    ctl_d.st  = S_FRD;
                end
            end
            S_FRD: if (ack_ev) begin
                ctl_d.wdata = fnew;
                ctl_d.st    = S_FWR;
            end
            S_FWR: if (ack_ev) begin
                if (ctl_q.fld == 3'(NFLD - 1)) begin
                    ctl_d.wdata = 32'd1;
                    ctl_d.st    = S_GO;
                end else begin
                    ctl_d.fld = ctl_q.fld + 3'd1;
                    ctl_d.st  = S_FRD;
                end
            end
            S_GO: if (ack_ev) ctl_d.st = S_PLOCK;
            S_PLOCK: if (ack_ev) begin
                if (bus_rdata[LOCK_BIT]) begin
                    ctl_d.st   = S_WAIT;
                    ctl_d.done = 1'b1;
                end else if (tmo) begin
                    ctl_d.st    = S_WAIT;
                    ctl_d.error = 1'b1;
                end
            end
            S_WKRD: if (ack_ev) begin
                if (bus_rdata[IDLE_BIT]) begin
                    ctl_d.wdata = bus_rdata & ~(32'd1 << IDLE_BIT);
                    ctl_d.st    = S_WKWR;
                end else begin
                    ctl_d.st   = S_WAIT;
                    ctl_d.done = 1'b1;
                end
            end
            S_WKWR: if (ack_ev) ctl_d.st = S_PLOCK;
            S_SLRD: if (ack_ev) begin
                ctl_d.wdata = bus_rdata | (32'd1 << IDLE_BIT);
                ctl_d.st    = S_SLWR;
            end
            S_SLWR: if (ack_ev) ctl_d.st = S_PPD;
            S_PPD: if (ack_ev) begin
                if (bus_rdata[OSC_PD_B] && bus_rdata[LDO_PD_B]) ctl_d.st = S_RRD;
                else if (tmo) begin
                    ctl_d.st    = S_WAIT;
                    ctl_d.error = 1'b1;
                end
            end
            S_RRD: if (ack_ev) begin
                ctl_d.hold  = bus_rdata;
                ctl_d.wdata = bus_rdata | (32'd1 << RST_BIT);
                ctl_d.st    = S_RSET;
            end
            S_RSET: if (ack_ev) begin
                ctl_d.wdata = ctl_q.hold & ~(32'd1 << RST_BIT);
                ctl_d.st    = S_RCLR;
            end
            S_RCLR: if (ack_ev) begin
                ctl_d.st   = S_WAIT;
                ctl_d.done = 1'b1;
            end
            default: ctl_d.st = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign bus_rd    = ctl_q.rd;
    assign bus_wr    = ctl_q.wr;
    assign bus_addr  = ctl_q.addr;
    assign bus_wdata = ctl_q.wdata;
    assign done      = ctl_q.done;
    assign error     = ctl_q.error;
    assign busy      = (ctl_q.st != S_WAIT);

    // R8: one strobe at a time, request held until acknowledged
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ack) |=>
            ($stable(bus_rd) && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)));
    // R9: result flags are single-cycle and exclusive
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, error}) <= 1);
    // R9: no bus traffic while not busy
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));
    // R2: the GO register only ever receives the value 1
    p_go_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_GO)) |-> (bus_wdata == 32'd1));
endmodule

// File: tb/pllseq_ctrl_bench.sv
module pllseq_ctrl_bench;
    localparam int          LIMIT   = 2000;   // 20000 Hz / 1000 * 100 ms
    localparam int          LAT     = 20;
    localparam logic [11:0] RSTA    = 12'h040;
    localparam logic [31:0] PRE1    = 32'hA5A5_A5A5;
    localparam logic [31:0] PRE2    = 32'h5A5A_5A50;
    localparam logic [31:0] PRE3    = 32'hC3C3_C3C3;
    localparam logic [31:0] PRE4    = 32'h3C3C_3C3C;
    localparam logic [31:0] PRERST  = 32'h0000_1234;
    localparam int          NVEC    = 8;
    // {rate_khz, expected M, expected hit}
    localparam logic [28:0] VEC [NVEC] = '{
        {16'd12000, 12'd1000, 1'b1}, {16'd16800, 12'd714, 1'b1},
        {16'd19200, 12'd625,  1'b1}, {16'd20000, 12'd600, 1'b1},
        {16'd26000, 12'd461,  1'b1}, {16'd38400, 12'd312, 1'b1},
        {16'd25000, 12'd0,    1'b0}, {16'd0,     12'd0,   1'b0}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, exit_req = 1'b0;
    logic [15:0] ref_khz = 16'd0;
    logic        bus_rd, bus_wr, done, error, busy;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    // register model
    logic [31:0] r_stat = '0, r_cfg1 = '0, r_cfg2 = '0, r_cfg3 = '0, r_cfg4 = '0, r_rst = '0;
    logic [31:0] pre_stat = '0, pre_cfg2 = '0;
    logic        load_req = 1'b0, lock_en = 1'b1, pd_en = 1'b1;
    int          lock_cnt = 0, pd_cnt = 0, nwr = 0;
    logic [11:0] wlog_a [32];
    logic [31:0] wlog_d [32];
    int          viol = 0;
    logic        p_req = 1'b0, p_ack = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
    logic [11:0] p_addr = '0;
    logic [31:0] p_wd = '0;
    int          checks = 0, fails = 0;

    always #5 clk = ~clk;

    pllseq_ctrl #(.CLK_HZ(20_000), .TIMEOUT_MS(100), .RST_ADDR(RSTA)) u_pllseq_ctrl (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
        .ref_khz(ref_khz), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .done(done), .error(error), .busy(busy));

    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (load_req) begin
            r_stat <= pre_stat; r_cfg1 <= PRE1; r_cfg2 <= pre_cfg2;
            r_cfg3 <= PRE3; r_cfg4 <= PRE4; r_rst <= PRERST;
            nwr <= 0; lock_cnt <= 0; pd_cnt <= 0;
        end else begin
            if (lock_cnt != 0) begin
                lock_cnt <= lock_cnt - 1;
                if (lock_cnt == 1 && lock_en) r_stat[1] <= 1'b1;
            end
            if (pd_cnt != 0) begin
                pd_cnt <= pd_cnt - 1;
                if (pd_cnt == 1 && pd_en) r_stat[16:15] <= 2'b11;
            end
            if ((bus_rd || bus_wr) && !bus_ack) begin
                bus_ack <= 1'b1;
                if (bus_rd) begin
                    case (bus_addr)
                        12'h004: bus_rdata <= r_stat;
                        12'h00C: bus_rdata <= r_cfg1;
                        12'h010: bus_rdata <= r_cfg2;
                        12'h014: bus_rdata <= r_cfg3;
                        12'h020: bus_rdata <= r_cfg4;
                        RSTA:    bus_rdata <= r_rst;
                        default: bus_rdata <= '0;
                    endcase
                end
                if (bus_wr) begin
                    wlog_a[nwr % 32] <= bus_addr;
                    wlog_d[nwr % 32] <= bus_wdata;
                    nwr <= nwr + 1;
                    case (bus_addr)
                        12'h008: if (bus_wdata == 32'd1) lock_cnt <= LAT;
                        12'h00C: r_cfg1 <= bus_wdata;
                        12'h010: begin
                            if (r_cfg2[0] && !bus_wdata[0]) begin
                                lock_cnt <= LAT; r_stat[16:15] <= 2'b00;
                            end
                            if (!r_cfg2[0] && bus_wdata[0]) begin
                                r_stat[1] <= 1'b0; pd_cnt <= LAT;
                            end
                            r_cfg2 <= bus_wdata;
                        end
                        12'h014: r_cfg3 <= bus_wdata;
                        12'h020: r_cfg4 <= bus_wdata;
                        RSTA:    r_rst  <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8 bus rule monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd && bus_wr) viol <= viol + 1;
            if (p_req && !p_ack && (bus_rd != p_rd || bus_wr != p_wr ||
                bus_addr != p_addr || bus_wdata != p_wd)) viol <= viol + 1;
        end
        p_req <= bus_rd || bus_wr; p_ack <= bus_ack;
        p_rd <= bus_rd; p_wr <= bus_wr; p_addr <= bus_addr; p_wd <= bus_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] st, input logic [31:0] c2);
        @(negedge clk);
        pre_stat = st; pre_cfg2 = c2; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic run_op(input bit is_init, input bit poke,
                          output bit gd, output bit ge, output int cyc);
        @(negedge clk);
        if (is_init) init_req = 1'b1; else exit_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0; exit_req = 1'b0;
        cyc = 1;
        while (!(done || error) && cyc < 20000) begin
            exit_req = poke && (cyc >= 10 && cyc < 13);
            init_req = poke && (cyc >= 20 && cyc < 22);
            @(negedge clk);
            cyc++;
        end
        exit_req = 1'b0; init_req = 1'b0;
        gd = done; ge = error;
        if (cyc >= 20000) begin
            fails++; checks++;
            $display("FAIL watchdog op act=%0d exp=<20000", cyc);
        end
    endtask

    initial begin
        bit gd, ge;
        int cyc;
        logic [31:0] e1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done/error", {30'd0, done, error}, 32'd0);
        chk("R10 strobes", {30'd0, bus_rd, bus_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4: table walk
        for (int v = 0; v < NVEC; v++) begin
            ref_khz = VEC[v][28:13];
            lock_en = 1'b1;
            preload(32'h0, PRE2);
            run_op(1'b1, 1'b0, gd, ge, cyc);
            if (VEC[v][0]) begin
                chk("R3 done", {30'd0, gd, ge}, 32'd2);
                e1 = (PRE1 & ~32'h001F_FFFE) | ({20'd0, VEC[v][12:1]} << 9) | (32'd7 << 1);
                chk("R1 cfg1", r_cfg1, e1);
                chk("R1 cfg2", r_cfg2, (PRE2 & ~32'hE) | (32'd4 << 1));
                chk("R1 cfg3", r_cfg3, (PRE3 & ~32'h0003_FC00) | (32'd6 << 10));
                chk("R1 cfg4", r_cfg4, PRE4 & ~32'h0003_FFFF);
                chk("R2 nwr", nwr, 6);
                chk("R2 order", {wlog_a[0], wlog_a[1], wlog_a[2], 20'd0},
                    {12'h00C, 12'h010, 12'h00C, 20'd0});
                chk("R2 order2", {wlog_a[3], wlog_a[4], wlog_a[5], 20'd0},
                    {12'h020, 12'h014, 12'h008, 20'd0});
                chk("R2 go", wlog_d[5], 32'd1);
            end else begin
                chk("R4 error", {30'd0, gd, ge}, 32'd1);
                chk("R4 nwr", nwr, 0);
            end
        end

        // R3: lock never comes
        ref_khz = 16'd19200; lock_en = 1'b0;
        preload(32'h0, PRE2);
        run_op(1'b1, 1'b0, gd, ge, cyc);
        chk("R3 timeout err", {30'd0, gd, ge}, 32'd1);
        chk("R3 timeout window", {31'd0, (cyc >= LIMIT) && (cyc <= LIMIT + 60)}, 32'd1);
        lock_en = 1'b1;

        // R5: locked, not idle
        preload(32'h2, PRE2);
        run_op(1'b1, 1'b0, gd, ge, cyc);
        chk("R5 done", {30'd0, gd, ge}, 32'd2);
        chk("R5 no writes", nwr, 0);

        // R5: locked, idle set
        preload(32'h2, PRE2 | 32'h1);
        run_op(1'b1, 1'b0, gd, ge, cyc);
        chk("R5 wake done", {30'd0, gd, ge}, 32'd2);
        chk("R5 wake cfg2", r_cfg2, PRE2);
        chk("R5 wake nwr", nwr, 1);

        // R6 R7: shutdown
        pd_en = 1'b1;
        preload(32'h2, PRE2);
        run_op(1'b0, 1'b0, gd, ge, cyc);
        chk("R6 done", {30'd0, gd, ge}, 32'd2);
        chk("R6 cfg2 idle", r_cfg2, PRE2 | 32'h1);
        chk("R7 nwr", nwr, 3);
        chk("R7 set", wlog_d[1], PRERST | (32'd1 << 18));
        chk("R7 clear", wlog_d[2], PRERST);
        chk("R7 addr", {wlog_a[1], wlog_a[2], 8'd0}, {RSTA, RSTA, 8'd0});

        // R6: power-down never reported
        pd_en = 1'b0;
        preload(32'h2, PRE2);
        run_op(1'b0, 1'b0, gd, ge, cyc);
        chk("R6 pd timeout", {30'd0, gd, ge}, 32'd1);
        chk("R6 no reset write", nwr, 1);
        chk("R6 rst reg", r_rst, PRERST);
        pd_en = 1'b1;

        // R9: requests while busy are ignored; one-cycle done
        ref_khz = 16'd26000;
        preload(32'h0, PRE2);
        run_op(1'b1, 1'b1, gd, ge, cyc);
        chk("R9 done", {30'd0, gd, ge}, 32'd2);
        @(negedge clk);
        chk("R9 pulse width", {30'd0, done, error}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R9 ignored nwr", nwr, 6);
        chk("R9 ignored cfg2", {31'd0, r_cfg2[0]}, 32'd0);
        chk("R9 idle", {29'd0, busy, bus_rd, bus_wr}, 32'd0);

        // R8 over the whole run
        chk("R8 bus rules", viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog global act=expired exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule